// File: doc/BRIEF.md
# Serial ADC Control-Byte Responder

This block models the digital side of an eight-input serial converter whose serial clock is supplied by the host. While idle it watches the serial data input. It waits for a sampled one, which it takes as the first bit of an 8-bit command. It then collects the remaining seven bits and keeps the whole command in a register that can be read on a port. The command selects an input and carries the polarity, input-pairing and clock/power flags.

When the last command bit arrives, the block raises a strobe for one serial clock period. At that same edge it captures the 12-bit value of the selected input from a parallel sample bus. It then shifts this value out MSB first on the falling edges that follow, and returns to idle. An active-low select input aborts any transfer at once. The logic runs directly on the host's serial clock, so it works at any clock rate.

Top module: `adc_ctrl_responder`

## Requirements
- R1: While idle, the block ignores a sampled zero on `din`. A command starts only at a rising edge of `sclk` that samples `din`=1, and that bit becomes command bit 7, so `ctrlReg[7]` is always 1 after a command.
- R2: A command is 8 bits, sampled on rising edges of `sclk`, MSB first. `ctrlReg` takes the new command at the rising edge that samples the eighth bit.
- R3: `strobe` goes high at the rising edge that samples the eighth command bit. It stays high for exactly one `sclk` period, once per command.
- R4: The 12 result bits are driven on `dout`, MSB first, on the 12 falling edges that follow the rising edge where `strobe` drops. Each bit holds until the next falling edge.
- R5: `dout` is 0 at every falling edge that does not drive a result bit.
- R6: `ctrlReg` keeps all 8 command bits until the next complete command. Command bits 6..4 select the input channel (0 to 7).
- R7: The result is `sampleBus[ch*12 +: 12]`, where ch is the selected channel, taken at the rising edge where `strobe` rises. Later changes on `sampleBus` do not alter a result already captured.
- R8: After the twelfth result bit the block is idle again and accepts a new command. Values on `din` while the strobe or the result is being sent are ignored.
- R9: `csN`=1 sampled at a rising edge returns the block to idle. An aborted command gives no strobe and leaves `ctrlReg` unchanged. An aborted result stops, and `dout` is 0 from the next falling edge.
- R10: While `rstN` is low, `strobe`, `dout` and `ctrlReg` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host; all logic runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; high aborts and holds idle |
| din | input | 1 | Serial command input, sampled on rising edges |
| sampleBus | input | 96 | Eight 12-bit sample words, channel c at bits c*12+11..c*12 |
| strobe | output | 1 | One-period pulse marking the end of a command |
| dout | output | 1 | Serial result output, changes on falling edges |
| ctrlReg | output | 8 | Last complete command byte |

## Verification
A bit counter that is off by one shows up within one command. The strobe appears one period early or late, and `ctrlReg` holds a shifted byte with a wrong channel field. A fault in the result path or the output counter shows in the same transfer. The collected 12-bit word is rotated or comes from the wrong channel, or `dout` stays high or comes back high on the falling edge after the last bit. A missing return to idle shows as an extra or missing strobe over the following idle cycles. A faulty abort shows as a strobe, a changed `ctrlReg` or a high `dout` within two clock edges of `csN` rising.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CTRL  = 2'd1,
    ST_STRB  = 2'd2,
    ST_SHIFT = 2'd3
  } respState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // take din into the command shifter
    logic latchByte;  // last command bit: store command, capture sample
    logic shiftOut;   // result bits are being driven
  } respStrobes_t;

endpackage

// File: rtl/adc_resp_ctrl.sv
module adc_resp_ctrl
  import adc_resp_pkg::*;
#(
  parameter int CTRL_BITS = 8,
  parameter int RES_BITS  = 12
) (
  input  logic         sclk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         din,
  output respStrobes_t st,
  output logic         strobe
);

  localparam int MAX_BITS = (CTRL_BITS > RES_BITS) ? CTRL_BITS : RES_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_BITS - 1);
  localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_BITS - 1);

  respState_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (csN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (din) begin
            state <= ST_CTRL;
            cnt   <= CNT_W'(1);
          end
        end
        ST_CTRL: begin
          if (cnt == CTRL_LAST) begin
            state <= ST_STRB;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STRB: begin
          state <= ST_SHIFT;
          cnt   <= '0;
        end
        ST_SHIFT: begin
          if (cnt == RES_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    st.shiftIn   = !csN && ((state == ST_IDLE && din) || state == ST_CTRL);
    st.latchByte = !csN && (state == ST_CTRL) && (cnt == CTRL_LAST);
    st.shiftOut  = (state == ST_SHIFT);
  end

  assign strobe = (state == ST_STRB);

  // R3: the strobe never lasts past one serial clock period
  p_strobe_single_r3: assert property (@(posedge sclk) disable iff (!rstN)
    strobe |=> !strobe);

  // R9: select high forces idle at the next edge
  p_abort_idle_r9: assert property (@(posedge sclk) disable iff (!rstN)
    csN |=> (state == ST_IDLE && !strobe));

  // R2: the command bit counter stays within one byte
  p_ctrl_count_r2: assert property (@(posedge sclk) disable iff (!rstN)
    (state == ST_CTRL) |-> (cnt >= CNT_W'(1) && cnt <= CTRL_LAST));

  // R8: strobe is always followed by the result phase or an abort
  p_strobe_then_shift_r8: assert property (@(posedge sclk) disable iff (!rstN)
    (strobe && !csN) |=> st.shiftOut);

endmodule

// File: rtl/adc_resp_datapath.sv
module adc_resp_datapath
  import adc_resp_pkg::*;
#(
  parameter int CTRL_BITS    = 8,
  parameter int RES_BITS     = 12,
  parameter int NUM_CH       = 8,
  parameter int CH_FIELD_LSB = 4
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       din,
  input  logic [NUM_CH*RES_BITS-1:0] sampleBus,
  input  respStrobes_t               st,
  output logic                       dout,
  output logic [CTRL_BITS-1:0]       ctrlReg
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [CTRL_BITS-2:0] byteShift;
  logic [CTRL_BITS-1:0] fullByte;
  logic [CH_W-1:0]      chanSel;
  logic [RES_BITS-1:0]  chanWord [NUM_CH];
  logic [RES_BITS-1:0]  selWord;
  logic [RES_BITS-1:0]  resShift;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chanWord[c] = sampleBus[c*RES_BITS +: RES_BITS];
  end

  assign fullByte = {byteShift, din};
  assign chanSel  = fullByte[CH_FIELD_LSB +: CH_W];
  assign selWord  = chanWord[chanSel];

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      byteShift <= '0;
      ctrlReg   <= '0;
      resShift  <= '0;
    end else begin
      if (st.shiftIn) begin
        byteShift <= fullByte[CTRL_BITS-2:0];
      end
      if (st.latchByte) begin
        ctrlReg  <= fullByte;
        resShift <= selWord;
      end else if (st.shiftOut) begin
        resShift <= {resShift[RES_BITS-2:0], 1'b0};
      end
    end
  end

  // result bits change on the falling edge
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) begin
      dout <= 1'b0;
    end else begin
      dout <= (st.shiftOut && !csN) ? resShift[RES_BITS-1] : 1'b0;
    end
  end

  // R6: the command register only moves on a completed byte
  p_ctrl_hold_r6: assert property (@(posedge sclk) disable iff (!rstN)
    !st.latchByte |=> $stable(ctrlReg));

  // R5: outside the result phase the falling-edge output stays low
  p_dout_quiet_r5: assert property (@(posedge sclk) disable iff (!rstN)
    !st.shiftOut |-> !dout);

  // R1: a stored command always carries its leading one
  p_lead_one_r1: assert property (@(posedge sclk) disable iff (!rstN)
    st.latchByte |=> ctrlReg[CTRL_BITS-1]);

endmodule

// File: rtl/adc_ctrl_responder.sv
module adc_ctrl_responder
  import adc_resp_pkg::*;
#(
  parameter int CTRL_BITS    = 8,
  parameter int RES_BITS     = 12,
  parameter int NUM_CH       = 8,
  parameter int CH_FIELD_LSB = 4
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       din,
  input  logic [NUM_CH*RES_BITS-1:0] sampleBus,
  output logic                       strobe,
  output logic                       dout,
  output logic [CTRL_BITS-1:0]       ctrlReg
);

  respStrobes_t st;

  adc_resp_ctrl #(
    .CTRL_BITS (CTRL_BITS),
    .RES_BITS  (RES_BITS)
  ) ctrl_i (
    .sclk   (sclk),
    .rstN   (rstN),
    .csN    (csN),
    .din    (din),
    .st     (st),
    .strobe (strobe)
  );

  adc_resp_datapath #(
    .CTRL_BITS    (CTRL_BITS),
    .RES_BITS     (RES_BITS),
    .NUM_CH       (NUM_CH),
    .CH_FIELD_LSB (CH_FIELD_LSB)
  ) dp_i (
    .sclk      (sclk),
    .rstN      (rstN),
    .csN       (csN),
    .din       (din),
    .sampleBus (sampleBus),
    .st        (st),
    .dout      (dout),
    .ctrlReg   (ctrlReg)
  );

endmodule

// File: tb/adc_ctrl_responder_tb_top.sv
module adc_ctrl_responder_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csN;
  logic        din;
  logic [95:0] sampleBus;
  logic        strobe;
  logic        dout;
  logic [7:0]  ctrlReg;

  int total = 0;
  int bad   = 0;
  int strobeCnt = 0;

  always #5 clk = ~clk;

  adc_ctrl_responder dut_i (
    .sclk      (clk),
    .rstN      (rstN),
    .csN       (csN),
    .din       (din),
    .sampleBus (sampleBus),
    .strobe    (strobe),
    .dout      (dout),
    .ctrlReg   (ctrlReg)
  );

  // strobe monitor: counts periods with strobe high
  always @(negedge clk) if (strobe === 1'b1) strobeCnt++;

  // {command byte, seed}
  localparam logic [15:0] VEC [8] = '{
    {8'h8F, 8'd1}, {8'hFF, 8'd2}, {8'hA0, 8'd3}, {8'hD3, 8'd4},
    {8'h90, 8'd5}, {8'hEE, 8'd6}, {8'hC1, 8'd7}, {8'hB8, 8'd8}
  };

  function automatic logic [11:0] sampleVal(int c, int seed);
    return 12'((seed * 577 + c * 1031 + 333) % 4096);
  endfunction

  task automatic loadBus(int seed);
    for (int c = 0; c < 8; c++) sampleBus[c*12 +: 12] = sampleVal(c, seed);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); #1 din = b[i];
    end
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 din = 1'b0;
    end
  endtask

  // full command plus result, with checks
  task automatic transfer(logic [7:0] b, int seed, int leadZeros, bit dinHigh);
    logic [11:0] word;
    logic [11:0] expWord;
    int s0;
    int ch;
    ch = int'(b[6:4]);
    loadBus(seed);
    expWord = sampleVal(ch, seed);
    s0 = strobeCnt;
    idleCycles(leadZeros);
    sendBits(b, 8);
    @(posedge clk); #2;
    chk(strobe === 1'b1, "R3 strobe at eighth bit", 32'(strobe), 1);
    chk(ctrlReg === b, "R2/R6 command stored", 32'(ctrlReg), 32'(b));
    din = 1'b0;
    @(posedge clk); #2;
    chk(strobe === 1'b0, "R3 strobe one period", 32'(strobe), 0);
    word = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #2;
      word = {word[10:0], dout};
      if (i == 3) begin
        sampleBus = ~sampleBus;   // R7: late change must not matter
        din = dinHigh;            // R8: ignored during result
      end
      if (i == 11) din = 1'b0;
    end
    chk(word === expWord, "R4/R7 result word", 32'(word), 32'(expWord));
    @(negedge clk); #2;
    chk(dout === 1'b0, "R5 dout low after last bit", 32'(dout), 0);
    idleCycles(3);
    chk(strobeCnt == s0 + 1, "R8/R1 single strobe per command", 32'(strobeCnt), 32'(s0 + 1));
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    logic [7:0] saved;
    int s0;
    rstN = 1'b0;
    csN  = 1'b0;
    din  = 1'b1;
    sampleBus = '1;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk(strobe === 1'b0, "R10 strobe in reset", 32'(strobe), 0);
    chk(dout === 1'b0, "R10 dout in reset", 32'(dout), 0);
    chk(ctrlReg === 8'h00, "R10 ctrlReg in reset", 32'(ctrlReg), 0);
    @(negedge clk); #1 din = 1'b0;
    @(negedge clk); #1 rstN = 1'b1;

    // R1: long run of zeros does nothing
    s0 = strobeCnt;
    idleCycles(20);
    chk(strobeCnt == s0, "R1 zeros ignored no strobe", 32'(strobeCnt), 32'(s0));
    chk(ctrlReg === 8'h00, "R1 zeros ignored ctrlReg", 32'(ctrlReg), 0);
    chk(dout === 1'b0, "R5 dout idle", 32'(dout), 0);

    // table of commands
    for (int v = 0; v < 8; v++) begin
      transfer(VEC[v][15:8], int'(VEC[v][7:0]), v, v[0]);
    end

    // R9: abort in the middle of a command
    saved = ctrlReg;
    s0 = strobeCnt;
    sendBits(8'hB5, 4);
    @(negedge clk); #1 csN = 1'b1; din = 1'b0;
    @(negedge clk); #1 csN = 1'b0;
    idleCycles(12);
    chk(strobeCnt == s0, "R9 aborted command no strobe", 32'(strobeCnt), 32'(s0));
    chk(ctrlReg === saved, "R9 aborted command keeps ctrlReg", 32'(ctrlReg), 32'(saved));

    // R9: abort in the middle of a result
    loadBus(11);
    sendBits(8'hFF, 8);
    @(posedge clk); #2 din = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
    end
    #2 csN = 1'b1;
    @(negedge clk); #2;
    chk(dout === 1'b0, "R9 dout low after abort", 32'(dout), 0);
    @(negedge clk); #1 csN = 1'b0;
    idleCycles(14);
    chk(dout === 1'b0, "R9 no resumed result", 32'(dout), 0);

    // recovery after aborts, R8 back-to-back commands
    transfer(8'hA5, 12, 0, 1'b1);
    transfer(8'hF0, 13, 0, 1'b0);

    finishRun();
  end

endmodule